// File: doc/BRIEF.md
# Miss Target List with Selective Release

This block keeps the ordered list of requests that are waiting on one outstanding read miss. Each waiting target carries three things: whether it came from the processor side or from a snoop, an identifier, and the time it arrived. New targets join at the tail as requests merge onto the miss. When the fill response arrives, the block marks which of the queued targets that response may satisfy. It then hands the marked targets out one per cycle, in list order, over a valid/ready stream.

A plain read response satisfies the whole list. A response that also invalidates the line gives a different result. It satisfies every snoop target, but only the earliest processor target. Letting the later processor targets see the data would break memory ordering, so they stay queued in their original relative order. When streaming ends, the block pulses a request for a fresh downstream read if anything is still queued. If nothing is left, it pulses that the miss entry is free.

Top module: `mshr_target_queue`

## Requirements
- R1: After reset the list is empty: `out_valid`, `app_stall`, `rereq`, `freed` and `inval_head_bad` are all low.
- R2: The list holds DEPTH (8) targets, appended at the tail in arrival order. `app_stall` is high exactly when 8 targets are held. An append offered while `app_stall` is high is dropped.
- R3: A response with `rsp_inval`=0, accepted while idle with a non-empty list, streams every queued target in arrival order and leaves none of them queued.
- R4: A response with `rsp_inval`=1 streams, in list order, every snoop target (`app_snoop`=1) and only the first processor target (`app_snoop`=0).
- R5: One cycle after the handshake of the last serviced target, exactly one of two pulses is high for a single cycle. `rereq` is high if any target remains queued; otherwise `freed` is high. Any targets that remain keep their relative order.
- R6: `inval_head_bad` is high, combinationally, in a cycle where an invalidating response would be accepted and the head target is a snoop target.
- R7: While `out_valid` is high and `out_ready` is low, the presented target (snoop flag, identifier, time) holds unchanged.
- R8: A target appended while a response is being serviced, or in the same cycle a response is accepted, is not serviced by that response. It joins the tail of the remaining list.
- R9: An append and a stream handshake in the same cycle both take effect: the handshaked target leaves and the appended one is queued.
- R10: `rsp_valid` is ignored while streaming is in progress and while the list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_valid | input | 1 | Offer a new target for the tail |
| app_snoop | input | 1 | 1 = snoop target, 0 = processor target |
| app_id | input | ID_W | Target identifier |
| app_time | input | TS_W | Arrival timestamp |
| app_stall | output | 1 | List full; appends are dropped |
| rsp_valid | input | 1 | Fill response arrives |
| rsp_inval | input | 1 | Response carries an invalidation |
| inval_head_bad | output | 1 | Invalidating response met a snoop head target |
| out_valid | output | 1 | A serviced target is presented |
| out_ready | input | 1 | Consumer takes the presented target |
| out_snoop | output | 1 | Source of the presented target |
| out_id | output | ID_W | Identifier of the presented target |
| out_time | output | TS_W | Arrival time of the presented target |
| rereq | output | 1 | One-cycle pulse: issue a new read for the remaining targets |
| freed | output | 1 | One-cycle pulse: list drained, entry free |

## Verification
The critical overlaps are these. An append can land in the same cycle as a stream handshake, which removes an entry from the middle of the list. An append can also coincide with the acceptance of a response, where it must end up unmarked at the tail. The bench provokes both by offering appends at random while responses are pending and `out_ready` toggles. A directed sequence also forces each case. A bench-side model of the serviced and remaining lists predicts every output in every cycle. After each extraction, a plain response drains the remainder, which shows whether the remaining order and contents survived the overlap.

// File: rtl/mshr_target_queue.sv
module mshr_target_queue #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8,
  parameter int TS_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            app_valid,
  input  logic            app_snoop,
  input  logic [ID_W-1:0] app_id,
  input  logic [TS_W-1:0] app_time,
  output logic            app_stall,
  input  logic            rsp_valid,
  input  logic            rsp_inval,
  output logic            inval_head_bad,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_snoop,
  output logic [ID_W-1:0] out_id,
  output logic [TS_W-1:0] out_time,
  output logic            rereq,
  output logic            freed
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] snp_q, mark_q, snp_n, mark_n;
  logic [ID_W-1:0]  id_q [DEPTH];
  logic [ID_W-1:0]  id_n [DEPTH];
  logic [TS_W-1:0]  ts_q [DEPTH];
  logic [TS_W-1:0]  ts_n [DEPTH];
  logic [CW-1:0]    cnt, cnt_n, wpos;
  logic             busy;
  logic [IW-1:0]    pidx, fcpu;
  logic             cpu_found;
  logic             pop, push, take;

  assign app_stall      = (cnt == CW'(DEPTH));
  assign out_valid      = busy && (|mark_q);
  assign pop            = out_valid && out_ready;
  assign push           = app_valid && !app_stall;
  assign take           = rsp_valid && !busy && (cnt != '0);
  assign inval_head_bad = take && rsp_inval && snp_q[0];
  assign out_snoop      = snp_q[pidx];
  assign out_id         = id_q[pidx];
  assign out_time       = ts_q[pidx];
  assign wpos           = cnt - CW'(pop);
  assign cnt_n          = cnt - CW'(pop) + CW'(push);

  always_comb begin
    pidx      = '0;
    fcpu      = '0;
    cpu_found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mark_q[i]) pidx = IW'(i);
      if (i < int'(cnt) && !snp_q[i]) begin
        fcpu      = IW'(i);
        cpu_found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && i >= int'(pidx)) begin
        if (i < DEPTH - 1) begin
          snp_n[i]  = snp_q[(i + 1) % DEPTH];
          mark_n[i] = mark_q[(i + 1) % DEPTH];
          id_n[i]   = id_q[(i + 1) % DEPTH];
          ts_n[i]   = ts_q[(i + 1) % DEPTH];
        end else begin
          snp_n[i]  = 1'b0;
          mark_n[i] = 1'b0;
          id_n[i]   = '0;
          ts_n[i]   = '0;
        end
      end else begin
        snp_n[i]  = snp_q[i];
        mark_n[i] = mark_q[i];
        id_n[i]   = id_q[i];
        ts_n[i]   = ts_q[i];
      end
      if (take)
        mark_n[i] = (i < int'(cnt)) &&
                    (!rsp_inval || snp_q[i] || (cpu_found && i == int'(fcpu)));
      if (push && i == int'(wpos)) begin
        snp_n[i]  = app_snoop;
        mark_n[i] = 1'b0;
        id_n[i]   = app_id;
        ts_n[i]   = app_time;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      rereq  <= 1'b0;
      freed  <= 1'b0;
      snp_q  <= '0;
      mark_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i] <= '0;
        ts_q[i] <= '0;
      end
    end else begin
      cnt    <= cnt_n;
      snp_q  <= snp_n;
      mark_q <= mark_n;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i] <= id_n[i];
        ts_q[i] <= ts_n[i];
      end
      rereq <= busy && (mark_n == '0) && (cnt_n != '0);
      freed <= busy && (mark_n == '0) && (cnt_n == '0);
      if (take)                         busy <= 1'b1;
      else if (busy && mark_n == '0)    busy <= 1'b0;
    end
  end

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    app_stall |=> cnt <= $past(cnt));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_id) &&
    $stable(out_time) && $stable(out_snoop));
  p_end_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rereq || freed));
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rereq || freed) |=> !(rereq || freed));
  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rereq && freed));
  p_empty_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !busy && cnt == '0 |=> !out_valid);
endmodule

// File: tb/mshr_target_queue_bench.sv
module mshr_target_queue_bench;
  localparam int DEPTH = 8;
  localparam int ID_W  = 8;
  localparam int TS_W  = 16;

  logic clk = 0, rst_n = 0;
  logic app_valid = 0, app_snoop = 0, rsp_valid = 0, rsp_inval = 0, out_ready = 0;
  logic [ID_W-1:0] app_id = '0;
  logic [TS_W-1:0] app_time = '0;
  logic app_stall, inval_head_bad, out_valid, out_snoop, rereq, freed;
  logic [ID_W-1:0] out_id;
  logic [TS_W-1:0] out_time;

  always #5 clk = ~clk;

  mshr_target_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .TS_W(TS_W)) u_mshr_target_queue (
    .clk(clk), .rst_n(rst_n), .app_valid(app_valid), .app_snoop(app_snoop),
    .app_id(app_id), .app_time(app_time), .app_stall(app_stall),
    .rsp_valid(rsp_valid), .rsp_inval(rsp_inval), .inval_head_bad(inval_head_bad),
    .out_valid(out_valid), .out_ready(out_ready), .out_snoop(out_snoop),
    .out_id(out_id), .out_time(out_time), .rereq(rereq), .freed(freed));

  typedef struct packed { logic s; logic [ID_W-1:0] id; logic [TS_W-1:0] ts; } tgt_t;
  tgt_t svcq[$], keepq[$];
  bit busy_m, inval_m, rereq_m, freed_m, held_m;
  int n_chk, n_bad;
  string ctx = "";
  int unsigned seed_sink;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string otag();
    if (ctx != "") return ctx;
    if (held_m) return "R7";
    return inval_m ? "R4" : "R3";
  endfunction

  task automatic step(bit av, bit as, logic [ID_W-1:0] aid, bit rv, bit ri, bit rdy);
    bit ev, hs, take, full, exp_bad;
    tgt_t e, nk[$];
    bit got_cpu;
    @(negedge clk);
    ev = busy_m && svcq.size() > 0;
    full = (svcq.size() + keepq.size()) == DEPTH;
    chk(out_valid == ev, otag(), "out_valid", out_valid, ev);
    if (ev && out_valid) begin
      chk(out_id == svcq[0].id, otag(), "out_id", out_id, svcq[0].id);
      chk(out_snoop == svcq[0].s, otag(), "out_snoop", out_snoop, svcq[0].s);
      chk(out_time == svcq[0].ts, otag(), "out_time", out_time, svcq[0].ts);
    end
    chk(app_stall == full, ctx != "" ? ctx : "R2", "app_stall", app_stall, full);
    chk(rereq == rereq_m, ctx != "" ? ctx : "R5", "rereq", rereq, rereq_m);
    chk(freed == freed_m, ctx != "" ? ctx : "R5", "freed", freed, freed_m);
    app_valid = av; app_snoop = as; app_id = aid; app_time = TS_W'($urandom);
    rsp_valid = rv; rsp_inval = ri; out_ready = rdy;
    #1;
    exp_bad = rv && ri && !busy_m && keepq.size() > 0 && keepq[0].s;
    chk(inval_head_bad == exp_bad, "R6", "inval_head_bad", inval_head_bad, exp_bad);
    hs = ev && rdy;
    held_m = ev && !rdy;
    if (hs) void'(svcq.pop_front());
    take = rv && !busy_m && keepq.size() > 0;
    if (take) begin
      got_cpu = 0;
      nk = {};
      foreach (keepq[i]) begin
        e = keepq[i];
        if (!ri || e.s || !got_cpu) begin
          svcq.push_back(e);
          if (!e.s) got_cpu = 1;
        end else nk.push_back(e);
      end
      keepq = nk;
      busy_m = 1;
      inval_m = ri;
    end
    if (av && !full) begin
      e.s = as; e.id = aid; e.ts = app_time;
      keepq.push_back(e);
    end
    rereq_m = 0; freed_m = 0;
    if (hs && busy_m && svcq.size() == 0) begin
      busy_m = 0;
      rereq_m = keepq.size() > 0;
      freed_m = keepq.size() == 0;
    end
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, rdy);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    seed_sink = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    ctx = "R1"; step(0, 0, '0, 0, 0, 0);
    ctx = "R10"; step(0, 0, '0, 1, 1, 1); idle(2, 1);
    // R2: fill to capacity, ninth append dropped
    ctx = "R2";
    pat = 8'b1110_1001;
    for (int i = 0; i < 8; i++) step(1, pat[i], ID_W'(i + 1), 0, 0, 0);
    step(1, 0, 8'hEE, 0, 0, 0);
    // R4 with ready stalls (R7), R10 ignored response while busy
    ctx = "";
    step(0, 0, '0, 1, 1, 0);
    step(0, 0, '0, 0, 0, 0);
    ctx = "R10"; step(0, 0, '0, 1, 0, 0);
    ctx = "R9"; step(1, 0, 8'h40, 0, 0, 1);
    ctx = "R8"; step(1, 1, 8'h41, 0, 0, 1);
    ctx = ""; idle(6, 1);
    // R3 drain remainder, then freed
    step(0, 0, '0, 1, 0, 1); idle(10, 1);
    // R6 snoop head, R8 append with accepted response
    step(1, 1, 8'h50, 0, 0, 0);
    step(1, 0, 8'h51, 0, 0, 0);
    step(1, 0, 8'h52, 0, 0, 0);
    ctx = "R8"; step(1, 0, 8'h53, 1, 1, 1);
    ctx = ""; idle(6, 1);
    step(0, 0, '0, 1, 0, 1); idle(8, 1);
    // R5: invalidating response on snoops only leaves nothing
    step(1, 1, 8'h60, 0, 0, 0); step(1, 1, 8'h61, 0, 0, 0);
    step(0, 0, '0, 1, 1, 1); idle(4, 1);
    // constrained random mix
    for (int c = 0; c < 4000; c++) begin
      step(($urandom % 3) == 0, ($urandom % 3) == 0, ID_W'($urandom),
           ($urandom % 7) == 0, ($urandom % 2) == 0, ($urandom % 10) < 7);
    end
    idle(12, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule